// File: doc/BRIEF.md
# SDRAM Single-Bank Access Timer

This block runs one complete access to one SDRAM bank. It opens a row, issues a single read or write burst, and then closes the row again. It places each command on the SDRAM command pins no earlier than the minimum gap in clocks that the timing parameters allow. A requester presents a row, a column, a bank, a direction, an auto-precharge choice, a per-beat mask and a CAS latency select. It raises `req_valid` while `busy` is low. The block takes a copy of the whole request on that edge and sequences the access from that copy.

Every pin output is registered. The activate reaches the pins in the cycle after acceptance, and every later event is counted in clocks from that activate. Read data return is announced on `rd_valid`, CAS latency clocks after the read command. Write beats are marked on `wr_beat`. The mask bits reach `dqm` with zero latency for writes and two clocks ahead of the data for reads. `done` marks the last cycle of the access. A request accepted in that cycle produces the next activate exactly when the row-precharge window has expired.

Top module: `sdr_bank_timer`

## Requirements
- R1: While reset is held, `cs_n`, `ras_n`, `cas_n` and `we_n` are high, and `busy`, `done`, `dqm`, `rd_valid` and `wr_beat` are low. After reset, a cycle with no access in progress drives a NOP: `cs_n` low, `ras_n`/`cas_n`/`we_n` high, `addr` and `ba` zero, all strobes low.
- R2: A request accepted at an edge (`req_valid` high, `busy` low) puts an activate on the pins in the next cycle. The activate is {ras_n,cas_n,we_n}=011, with `addr` equal to the row and `ba` equal to the bank. This cycle is called cycle 0 below.
- R3: The column command appears in cycle T_RCD. A read is 101 and a write is 100. `addr[8:0]` carries the column, `addr[10]` carries the auto-precharge choice, and every other address bit is zero.
- R4: With auto-precharge off, a precharge (010, `addr` zero, `ba` equal to the bank) appears in cycle P. For a read, P = max(T_RAS, T_RCD+CL+BL-2). For a write, P = max(T_RAS, T_RCD+BL-1+T_RDL). Every other cycle of the access is a NOP.
- R5: With auto-precharge on, no precharge command reaches the pins. The access keeps the same length as it would have with an explicit precharge.
- R6: For a read, `rd_valid` is high for BL cycles starting in cycle T_RCD+CL. CL is 2 when `cas_lat3` is 0 and 3 when it is 1.
- R7: For a write, `wr_beat` is high in cycles T_RCD to T_RCD+BL-1. In beat k of those cycles, `dqm` equals mask bit k.
- R8: For a read, `dqm` equals mask bit k in cycle T_RCD+CL-2+k, which is two cycles before beat k's data. `dqm` is low in every other cycle.
- R9: `done` is high for exactly one cycle, cycle E = max(P+T_RP, T_RC)-1. `busy` is high in cycles 0 to E-1 and low in cycle E.
- R10: A request presented while `busy` is high is ignored. The access in progress and the pins are unaffected.
- R11: The direction, address, mask, auto-precharge and `cas_lat3` are taken from the accepted request. Changes to these inputs during the access have no effect on it.
- R12: A request accepted in the `done` cycle activates exactly T_RP cycles after the previous precharge slot, and at least T_RC cycles after the previous activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_autopre | input | 1 | Close the row automatically at burst end |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_bank | input | BANK_W | Bank select |
| req_mask | input | BL | Per-beat mask, bit k for beat k |
| cas_lat3 | input | 1 | 0 selects CAS latency 2, 1 selects 3 |
| busy | output | 1 | Access in progress; requests ignored |
| done | output | 1 | Last cycle of the access |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| addr | output | ROW_W | Multiplexed address |
| ba | output | BANK_W | Bank address |
| dqm | output | 1 | Data mask |
| rd_valid | output | 1 | Read data present on the data bus |
| wr_beat | output | 1 | Write beat to be driven this cycle |

## Verification
The bench runs reads at both CAS latencies, which moves both `rd_valid` and the read mask window by one cycle. A design that decoded the latency select wrongly, or applied the read mask with zero latency, would show the mask on the wrong beat. Auto-precharge accesses check that no precharge leaks onto the pins while the access length stays the same. Requests with every field inverted and the opposite latency arrive while `busy` is high, which catches a design that reloads its request or reads `cas_lat3` live. Back-to-back accesses and all-ones row and column values check the reopen spacing and that the auto-precharge bit lands on A10 without overwriting column bits.

// File: rtl/sdr_tmr_pkg.sv
package sdr_tmr_pkg;

    // Command code on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } sdr_cmd_e;

    // Address bit that carries the auto-precharge request on a column command
    localparam int AP_BIT = 10;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_tmr_win.sv
// Precharge slot and final cycle of an access, counted from the activate.
module sdr_tmr_win
    import sdr_tmr_pkg::*;
#(
    parameter int BL    = 4,
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RC  = 7,
    parameter int T_RP  = 2,
    parameter int T_RDL = 2,
    parameter int CW    = 5
) (
    input  logic          wr,
    input  logic          cl3,
    output logic [CW-1:0] pre_at,
    output logic [CW-1:0] last_at
);
    // Read with CL=2: T_RCD + 2 + BL - 2; with CL=3: T_RCD + 3 + BL - 2
    localparam int PRE_RD2 = imax(T_RAS, T_RCD + BL);
    localparam int PRE_RD3 = imax(T_RAS, T_RCD + BL + 1);
    localparam int PRE_WR  = imax(T_RAS, T_RCD + BL - 1 + T_RDL);
    localparam int END_RD2 = imax(PRE_RD2 + T_RP, T_RC) - 1;
    localparam int END_RD3 = imax(PRE_RD3 + T_RP, T_RC) - 1;
    localparam int END_WR  = imax(PRE_WR + T_RP, T_RC) - 1;

    always_comb begin
        if (wr) begin
            pre_at  = CW'(PRE_WR);
            last_at = CW'(END_WR);
        end else if (cl3) begin
            pre_at  = CW'(PRE_RD3);
            last_at = CW'(END_RD3);
        end else begin
            pre_at  = CW'(PRE_RD2);
            last_at = CW'(END_RD2);
        end
    end
endmodule

// File: rtl/sdr_tmr_beat.sv
// Data-phase strobes: read return window and mask placement per beat.
module sdr_tmr_beat #(
    parameter int BL    = 4,
    parameter int T_RCD = 2,
    parameter int CW    = 5
) (
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          wr,
    input  logic          cl3,
    input  logic [BL-1:0] mask,
    output logic          dqm,
    output logic          rdv,
    output logic          wrb
);
    logic [CW-1:0] rd_start;
    logic [CW-1:0] msk_start;
    logic [BL-1:0] in_msk;
    logic [BL-1:0] in_rd;

    always_comb begin
        rd_start  = CW'(T_RCD) + (cl3 ? CW'(3) : CW'(2));
        // write mask has latency 0, read mask leads the data by 2
        msk_start = wr ? CW'(T_RCD) : (rd_start - CW'(2));
    end

    for (genvar k = 0; k < BL; k++) begin : g_beat
        assign in_msk[k] = (cnt == msk_start + CW'(k));
        assign in_rd[k]  = (cnt == rd_start + CW'(k));
    end

    assign dqm = run && (|(in_msk & mask));
    assign rdv = run && !wr && (|in_rd);
    assign wrb = run && wr && (|in_msk);
endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer
    import sdr_tmr_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int BL     = 4,
    parameter int T_RCD  = 2,
    parameter int T_RAS  = 5,
    parameter int T_RC   = 7,
    parameter int T_RP   = 2,
    parameter int T_RDL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [BL-1:0]     req_mask,
    input  logic              cas_lat3,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] ba,
    output logic              dqm,
    output logic              rd_valid,
    output logic              wr_beat
);
    localparam int PRE_MAX = imax(T_RAS, imax(T_RCD + BL + 1, T_RCD + BL - 1 + T_RDL));
    localparam int END_MAX = imax(PRE_MAX + T_RP, T_RC);
    localparam int CW      = $clog2(END_MAX + 1) + 1;

    // parameter sanity, checked at elaboration
    if (T_RC < T_RAS + T_RP) begin : g_trc_bad
        $error("row cycle shorter than active time plus precharge time");
    end
    if (T_RCD < 1 || T_RDL < 1 || T_RP < 1) begin : g_gap_bad
        $error("timing gaps must be at least one clock");
    end
    if (ROW_W <= AP_BIT || COL_W > AP_BIT) begin : g_addr_bad
        $error("address widths do not leave room for the auto-precharge bit");
    end

    typedef struct packed {
        logic              wr;
        logic              ap;
        logic              cl3;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
        logic [BL-1:0]     mask;
    } fld_t;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } ctl_t;

    typedef struct packed {
        logic              cs_n;
        sdr_cmd_e          cmd;
        logic [ROW_W-1:0]  addr;
        logic [BANK_W-1:0] ba;
        logic              dqm;
        logic              rdv;
        logic              wrb;
        logic              done;
        logic              busy;
    } pin_t;

    localparam pin_t PIN_RST = '{cs_n: 1'b1, cmd: CMD_NOP, addr: '0, ba: '0,
                                 dqm: 1'b0, rdv: 1'b0, wrb: 1'b0, done: 1'b0, busy: 1'b0};

    fld_t f_q, f_d;
    ctl_t c_q, c_d;
    pin_t p_q, p_d;

    logic          accept;
    logic [CW-1:0] pre_at;
    logic [CW-1:0] last_at;
    logic          b_dqm, b_rdv, b_wrb;

    assign accept = req_valid && !p_q.busy;

    // request capture
    always_comb begin
        f_d = f_q;
        if (accept) begin
            f_d.wr   = req_write;
            f_d.ap   = req_autopre;
            f_d.cl3  = cas_lat3;
            f_d.row  = req_row;
            f_d.col  = req_col;
            f_d.bank = req_bank;
            f_d.mask = req_mask;
        end
    end

    sdr_tmr_win #(
        .BL(BL), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_RP(T_RP), .T_RDL(T_RDL), .CW(CW)
    ) u_win (
        .wr      (f_d.wr),
        .cl3     (f_d.cl3),
        .pre_at  (pre_at),
        .last_at (last_at)
    );

    // cycle counter from the activate
    always_comb begin
        c_d = c_q;
        if (accept) begin
            c_d.run = 1'b1;
            c_d.cnt = '0;
        end else if (c_q.run) begin
            if (c_q.cnt == last_at) begin
                c_d.run = 1'b0;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    sdr_tmr_beat #(
        .BL(BL), .T_RCD(T_RCD), .CW(CW)
    ) u_beat (
        .run  (c_d.run),
        .cnt  (c_d.cnt),
        .wr   (f_d.wr),
        .cl3  (f_d.cl3),
        .mask (f_d.mask),
        .dqm  (b_dqm),
        .rdv  (b_rdv),
        .wrb  (b_wrb)
    );

    // next pin values
    always_comb begin
        p_d      = PIN_RST;
        p_d.cs_n = 1'b0;
        if (c_d.run) begin
            if (c_d.cnt == '0) begin
                p_d.cmd  = CMD_ACT;
                p_d.addr = f_d.row;
                p_d.ba   = f_d.bank;
            end else if (c_d.cnt == CW'(T_RCD)) begin
                p_d.cmd                = f_d.wr ? CMD_WR : CMD_RD;
                p_d.addr[COL_W-1:0]    = f_d.col;
                p_d.addr[AP_BIT]       = f_d.ap;
                p_d.ba                 = f_d.bank;
            end else if (c_d.cnt == pre_at && !f_d.ap) begin
                p_d.cmd = CMD_PRE;
                p_d.ba  = f_d.bank;
            end
            p_d.done = (c_d.cnt == last_at);
            p_d.busy = (c_d.cnt != last_at);
        end
        p_d.dqm = b_dqm;
        p_d.rdv = b_rdv;
        p_d.wrb = b_wrb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
            c_q <= '0;
            p_q <= PIN_RST;
        end else begin
            f_q <= f_d;
            c_q <= c_d;
            p_q <= p_d;
        end
    end

    assign cs_n     = p_q.cs_n;
    assign ras_n    = p_q.cmd[2];
    assign cas_n    = p_q.cmd[1];
    assign we_n     = p_q.cmd[0];
    assign addr     = p_q.addr;
    assign ba       = p_q.ba;
    assign dqm      = p_q.dqm;
    assign rd_valid = p_q.rdv;
    assign wr_beat  = p_q.wrb;
    assign done     = p_q.done;
    assign busy     = p_q.busy;

    // ---------------- pin-level spacing checks ----------------
    logic [7:0] since_act_q, since_pre_q, since_wrb_q;

    function automatic logic [7:0] sat_inc(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act_q <= 8'hFF;
            since_pre_q <= 8'hFF;
            since_wrb_q <= 8'hFF;
        end else begin
            since_act_q <= (p_q.cmd == CMD_ACT) ? 8'd1 : sat_inc(since_act_q);
            since_pre_q <= (p_q.cmd == CMD_PRE) ? 8'd1 : sat_inc(since_pre_q);
            since_wrb_q <= p_q.wrb ? 8'd1 : sat_inc(since_wrb_q);
        end
    end

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cmd == CMD_RD || p_q.cmd == CMD_WR) |-> (int'(since_act_q) == T_RCD));

    // R4
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cmd == CMD_PRE) |-> (int'(since_act_q) >= T_RAS));

    // R4
    rdl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cmd == CMD_PRE) |-> (int'(since_wrb_q) >= T_RDL));

    // R12
    rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cmd == CMD_ACT) |-> (int'(since_act_q) >= T_RC));

    // R12
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cmd == CMD_ACT) |-> (int'(since_pre_q) >= T_RP));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_beat |-> !rd_valid);
endmodule

// File: tb/tb_sdr_bank_timer.sv
`timescale 1ns/1ps
module tb_sdr_bank_timer;
    localparam int BL = 4, T_RCD = 2, T_RAS = 5, T_RC = 7, T_RP = 2, T_RDL = 2;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0, cas_lat3 = 1'b0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [1:0]  req_bank = '0;
    logic [3:0]  req_mask = '0;
    logic busy, done, cs_n, ras_n, cas_n, we_n, dqm, rd_valid, wr_beat;
    logic [11:0] addr;
    logic [1:0]  ba;

    always #2 clk = ~clk;

    sdr_bank_timer #(
        .ROW_W(12), .COL_W(9), .BANK_W(2), .BL(BL), .T_RCD(T_RCD),
        .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .T_RDL(T_RDL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_autopre(req_autopre), .req_row(req_row), .req_col(req_col),
        .req_bank(req_bank), .req_mask(req_mask), .cas_lat3(cas_lat3),
        .busy(busy), .done(done), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm), .rd_valid(rd_valid),
        .wr_beat(wr_beat)
    );

    typedef struct {
        int          when;
        logic [2:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  ba;
        logic        dqm, rdv, wrb, done, busy, wr;
        int          ctag;
        int          ctx;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   cur_bad;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string ctx_text(input int c);
        case (c)
            1: return "R6 read CL2";
            2: return "R8 read CL3 masked";
            3: return "R7 write masked";
            4: return "R5 read autoprecharge";
            5: return "R5 write autoprecharge";
            6: return "R10 R11 busy stimulus";
            7: return "R12 back-to-back";
            8: return "R3 address limits";
            default: return "R1 idle";
        endcase
    endfunction

    function automatic string cmd_tag(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            5: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic cmp(input string tag, input int ctx, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            $display("FAIL %s [%s] %s actual=%0h expected=%0h at cycle %0d",
                     tag, ctx_text(ctx), name, act, exp, cyc);
            cur_bad = 1'b1;
        end
    endtask

    // monitor: pops the expected snapshot for each cycle of an access
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (q.size() > 0 && q[0].when < cyc) begin
                e = q.pop_front();
                checks++; errors++;
                $display("FAIL %s [%s] item missed actual=%0d expected=%0d",
                         cmd_tag(e.ctag), ctx_text(e.ctx), cyc, e.when);
            end else if (q.size() > 0 && q[0].when == cyc) begin
                e = q.pop_front();
                cur_bad = 1'b0;
                cmp(cmd_tag(e.ctag), e.ctx, "cmd", 32'({ras_n, cas_n, we_n}), 32'(e.cmd));
                cmp(cmd_tag(e.ctag), e.ctx, "cs_n", 32'(cs_n), 32'(0));
                cmp(cmd_tag(e.ctag), e.ctx, "addr", 32'(addr), 32'(e.addr));
                cmp(cmd_tag(e.ctag), e.ctx, "ba", 32'(ba), 32'(e.ba));
                cmp(e.wr ? "R7" : "R8", e.ctx, "dqm", 32'(dqm), 32'(e.dqm));
                cmp("R7", e.ctx, "wr_beat", 32'(wr_beat), 32'(e.wrb));
                cmp("R6", e.ctx, "rd_valid", 32'(rd_valid), 32'(e.rdv));
                cmp("R9", e.ctx, "done", 32'(done), 32'(e.done));
                cmp("R9", e.ctx, "busy", 32'(busy), 32'(e.busy));
                checks++;
                if (cur_bad) errors++;
            end else if (q.size() == 0) begin
                cur_bad = 1'b0;
                // R1 idle pins between accesses
                cmp("R1", 0, "idle pins", 32'({cs_n, ras_n, cas_n, we_n, addr, ba}),
                    32'({1'b0, C_NOP, 12'h0, 2'b0}));
                cmp("R1", 0, "idle strobes", 32'({busy, done, dqm, rd_valid, wr_beat}), 32'(0));
                checks++;
                if (cur_bad) errors++;
            end
        end
    end

    task automatic run_txn(input bit wr, input bit ap, input bit cl3,
                           input logic [11:0] row, input logic [8:0] col,
                           input logic [1:0] bank, input logic [3:0] mask,
                           input int ctx, input int pokes);
        int n, cl, pre, last, ms;
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_autopre = ap; cas_lat3 = cl3;
        req_row = row; req_col = col; req_bank = bank; req_mask = mask;
        n    = cyc;
        cl   = cl3 ? 3 : 2;
        pre  = wr ? ((T_RAS > T_RCD + BL - 1 + T_RDL) ? T_RAS : T_RCD + BL - 1 + T_RDL)
                  : ((T_RAS > T_RCD + cl + BL - 2) ? T_RAS : T_RCD + cl + BL - 2);
        last = ((pre + T_RP > T_RC) ? pre + T_RP : T_RC) - 1;
        ms   = wr ? T_RCD : T_RCD + cl - 2;
        for (int c = 0; c <= last; c++) begin
            e.when = n + 1 + c; e.cmd = C_NOP; e.addr = '0; e.ba = '0;
            e.wr = wr; e.ctx = ctx; e.ctag = 4;
            if (c == 0) begin
                e.cmd = C_ACT; e.addr = row; e.ba = bank; e.ctag = 2;
            end else if (c == T_RCD) begin
                e.cmd = wr ? C_WR : C_RD; e.addr = {1'b0, ap, 1'b0, col}; e.ba = bank; e.ctag = 3;
            end else if (c == pre) begin
                if (ap) e.ctag = 5;
                else begin e.cmd = C_PRE; e.ba = bank; end
            end
            e.rdv  = !wr && c >= T_RCD + cl && c < T_RCD + cl + BL;
            e.wrb  = wr && c >= T_RCD && c < T_RCD + BL;
            e.dqm  = (c >= ms && c < ms + BL) ? mask[c - ms] : 1'b0;
            e.done = (c == last);
            e.busy = (c != last);
            q.push_back(e);
        end
        @(negedge clk);
        for (int p = 0; p < pokes; p++) begin
            req_row = ~row; req_col = ~col; req_bank = ~bank; req_write = !wr;
            req_autopre = !ap; cas_lat3 = !cl3; req_mask = ~mask;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_bad = 1'b0;
        // R1 reset values
        cmp("R1", 0, "reset pins", 32'({cs_n, ras_n, cas_n, we_n}), 32'(4'b1111));
        cmp("R1", 0, "reset strobes", 32'({busy, done, dqm, rd_valid, wr_beat}), 32'(0));
        checks++;
        if (cur_bad) errors++;
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        idle(2);
        run_txn(1'b0, 1'b0, 1'b0, 12'h123, 9'h045, 2'd1, 4'b0000, 1, 0);
        idle(3);
        run_txn(1'b0, 1'b0, 1'b1, 12'h456, 9'h0A7, 2'd2, 4'b0101, 2, 0);
        idle(2);
        run_txn(1'b0, 1'b0, 1'b0, 12'h456, 9'h0A7, 2'd2, 4'b0110, 2, 0);
        idle(2);
        run_txn(1'b1, 1'b0, 1'b0, 12'h789, 9'h111, 2'd3, 4'b1010, 3, 0);
        idle(2);
        run_txn(1'b0, 1'b1, 1'b0, 12'h0F0, 9'h00F, 2'd0, 4'b1001, 4, 0);
        idle(2);
        run_txn(1'b1, 1'b1, 1'b1, 12'hABC, 9'h155, 2'd1, 4'b0011, 5, 0);
        idle(2);
        run_txn(1'b0, 1'b0, 1'b0, 12'h321, 9'h033, 2'd2, 4'b1100, 6, 3);
        idle(2);
        run_txn(1'b1, 1'b0, 1'b1, 12'h654, 9'h1AA, 2'd0, 4'b0001, 6, 3);
        idle(2);
        run_txn(1'b1, 1'b0, 1'b0, 12'h111, 9'h001, 2'd1, 4'b1000, 7, 0);
        run_txn(1'b0, 1'b0, 1'b1, 12'h222, 9'h002, 2'd2, 4'b0010, 7, 0);
        run_txn(1'b0, 1'b1, 1'b0, 12'h333, 9'h003, 2'd3, 4'b0100, 7, 0);
        run_txn(1'b1, 1'b0, 1'b0, 12'h444, 9'h004, 2'd0, 4'b1111, 7, 0);
        idle(2);
        run_txn(1'b0, 1'b1, 1'b1, 12'hFFF, 9'h1FF, 2'd3, 4'b1111, 8, 0);
        idle(2);
        run_txn(1'b1, 1'b0, 1'b0, 12'h000, 9'h1FF, 2'd3, 4'b0000, 8, 0);
        while (q.size() > 0) @(negedge clk);
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule